// File: doc/BRIEF.md
# Dispatch Width Gate with Carry-Over

This block decides, clock by clock, whether the instruction offered to the dispatch stage may leave this cycle. Each dispatch cycle grants a budget of micro-op slots equal to the dispatch width. An instruction is admitted when its micro-op count fits the remaining budget and the three downstream resources (reorder-buffer room, rename-register room and scheduler-buffer room) all report ready. These readiness flags come in from structures outside the block.

One instruction is offered per clock, and several clocks may make up one dispatch cycle. The `cycle_tick` input closes the current dispatch cycle at that edge. An instruction with more micro-ops than the width can still be admitted, but only while the budget is untouched. Its surplus is carried over and eats the budget of the cycles that follow. When an admissible instruction is refused for lack of a resource, one saturating stall counter is charged, chosen by a fixed priority among the three causes.

A small state machine tracks the budget. The states are GS_FULL (nothing spent yet), GS_PART (some slots spent) and GS_DRAINED (no slots left). The transitions are: SPEND (GS_FULL to GS_PART), EXHAUST (GS_FULL or GS_PART to GS_DRAINED, by admission or by a tick that leaves carry-over), REFILL (any state to GS_FULL on a tick with no carry-over left), and PARTIAL_REFILL (GS_DRAINED to GS_PART on a tick that leaves some carry-over).

Top module: `dispatch_width_gate`

## Requirements
- R1: After reset `budget_left` equals WIDTH, `carry_left` is 0, `gate_state` is 0 and all three stall counters are 0.
- R2: `fire` is high in a clock only when `in_valid` is high, `budget_left` is nonzero, and either `in_uops` <= `budget_left` or `budget_left` equals WIDTH. An instruction of zero micro-ops meets this rule.
- R3: `fire` additionally requires `rob_ok`, `ren_ok` and `sch_ok` all high.
- R4: On a firing edge, `in_uops` is subtracted from the budget. If `in_uops` exceeds the budget, the budget becomes 0 and the excess is added to `carry_left`. `budget_left` never exceeds WIDTH.
- R5: At an edge with `cycle_tick` high, any admission at that edge is applied first. Then the budget becomes WIDTH minus carry-over, floored at 0, and the carry-over is reduced by WIDTH, floored at 0.
- R6: At an edge with neither `cycle_tick` nor `fire`, `budget_left` and `carry_left` keep their values.
- R7: When an instruction is valid, has a nonzero budget and fits, but a resource flag is low, exactly one counter increments. The choice follows priority: `stall_rob` if `rob_ok` is low, else `stall_ren` if `ren_ok` is low, else `stall_sch`.
- R8: While `budget_left` is 0, `fire` stays low and no stall counter changes.
- R9: Each stall counter saturates at all ones.
- R10: `gate_state` is 0 when `budget_left` equals WIDTH, 2 when it is 0, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered this clock |
| in_uops | input | UOP_W | Micro-op count of the offered instruction |
| rob_ok | input | 1 | Reorder buffer has room |
| ren_ok | input | 1 | Enough rename registers for the destinations |
| sch_ok | input | 1 | Scheduler buffer has room |
| cycle_tick | input | 1 | Closes the dispatch cycle at this edge |
| fire | output | 1 | Offered instruction is admitted this clock |
| budget_left | output | $clog2(WIDTH+1) | Slots remaining in the current cycle |
| carry_left | output | UOP_W | Surplus micro-ops charged to later cycles |
| gate_state | output | 2 | 0 full, 1 partial, 2 drained |
| stall_rob | output | CNT_W | Stalls charged to the reorder buffer |
| stall_ren | output | CNT_W | Stalls charged to rename registers |
| stall_sch | output | CNT_W | Stalls charged to the scheduler buffer |

## Verification
The bench builds the gate with WIDTH=3, UOP_W=3 and CNT_W=3. With these values every micro-op count from 0 to 7 can be offered, against every combination of the three readiness flags, with and without a tick. Counts from 4 to 7 exceed the width, so carry-over spans one or two later cycles and every budget value from 0 to 3 is reached. Three-bit counters reach saturation within the sweep, so the hold at 7 is exercised under continued stalls.

// File: rtl/dwg_pkg.sv
package dwg_pkg;

    typedef enum logic [1:0] {
        GS_FULL    = 2'd0,
        GS_PART    = 2'd1,
        GS_DRAINED = 2'd2
    } gate_state_e;

    localparam int NUM_CAUSES = 3;
    localparam int C_ROB      = 0;
    localparam int C_REN      = 1;
    localparam int C_SCH      = 2;

endpackage

// File: rtl/dwg_admit.sv
module dwg_admit
    import dwg_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int UOP_W = 4,
    parameter int BW    = 3
) (
    input  logic                  in_valid,
    input  logic [UOP_W-1:0]      in_uops,
    input  logic                  rob_ok,
    input  logic                  ren_ok,
    input  logic                  sch_ok,
    input  logic [BW-1:0]         budget,
    output logic                  fire,
    output logic [NUM_CAUSES-1:0] stall_hit
);

    localparam int SW = ((UOP_W > BW) ? UOP_W : BW) + 1;

    logic [SW-1:0] need;
    logic [SW-1:0] have;
    logic          open_w;
    logic          fits;
    logic          cand;
    logic          all_ok;

    assign need   = SW'(in_uops);
    assign have   = SW'(budget);
    assign open_w = (budget != '0);
    assign fits   = (need <= have) || (have == SW'(WIDTH));
    assign cand   = in_valid && open_w && fits;
    assign all_ok = rob_ok && ren_ok && sch_ok;
    assign fire   = cand && all_ok;

    // priority: reorder buffer, then rename, then scheduler
    always_comb begin
        stall_hit = '0;
        if (cand && !all_ok) begin
            if (!rob_ok) begin
                stall_hit[C_ROB] = 1'b1;
            end else if (!ren_ok) begin
                stall_hit[C_REN] = 1'b1;
            end else begin
                stall_hit[C_SCH] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dwg_budget.sv
module dwg_budget
    import dwg_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int UOP_W = 4,
    parameter int BW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [UOP_W-1:0] uops,
    input  logic             tick,
    output logic [BW-1:0]    budget_o,
    output logic [UOP_W-1:0] carry_o,
    output gate_state_e      state_o
);

    localparam int SW = ((UOP_W > BW) ? UOP_W : BW) + 2;

    gate_state_e      state_q, state_d;
    logic [BW-1:0]    budget_q;
    logic [UOP_W-1:0] carry_q;

    logic [SW-1:0] wid, have, need, car;
    logic [SW-1:0] pb, pc, nb, nc;

    assign wid  = SW'(WIDTH);
    assign have = SW'(budget_q);
    assign need = SW'(uops);
    assign car  = SW'(carry_q);

    // admission first, then cycle boundary
    always_comb begin
        pb = have;
        pc = car;
        if (fire) begin
            if (need > have) begin
                pb = '0;
                pc = car + need - have;
            end else begin
                pb = have - need;
            end
        end
        nb = pb;
        nc = pc;
        if (tick) begin
            if (pc >= wid) begin
                nb = '0;
                nc = pc - wid;
            end else begin
                nb = wid - pc;
                nc = '0;
            end
        end
    end

    // next-state logic with named transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_FULL: begin
                if (nb == '0)       state_d = GS_DRAINED;   // EXHAUST
                else if (nb != wid) state_d = GS_PART;      // SPEND
            end
            GS_PART: begin
                if (nb == wid)      state_d = GS_FULL;      // REFILL
                else if (nb == '0)  state_d = GS_DRAINED;   // EXHAUST
            end
            GS_DRAINED: begin
                if (nb == wid)      state_d = GS_FULL;      // REFILL
                else if (nb != '0)  state_d = GS_PART;      // PARTIAL_REFILL
            end
            default:                state_d = GS_FULL;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= GS_FULL;
            budget_q <= BW'(WIDTH);
            carry_q  <= '0;
        end else begin
            state_q  <= state_d;
            budget_q <= nb[BW-1:0];
            carry_q  <= nc[UOP_W-1:0];
        end
    end

    // outputs
    always_comb begin
        budget_o = budget_q;
        carry_o  = carry_q;
        state_o  = state_q;
    end

endmodule

// File: rtl/dwg_stall_ctr.sv
module dwg_stall_ctr #(
    parameter int CNT_W = 8,
    parameter int N     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     hit,
    output logic [N*CNT_W-1:0] count
);

    for (genvar gi = 0; gi < N; gi++) begin : g_ctr
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (hit[gi] && (cnt_q != {CNT_W{1'b1}})) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
        assign count[gi*CNT_W +: CNT_W] = cnt_q;
    end

endmodule

// File: rtl/dispatch_width_gate.sv
module dispatch_width_gate
    import dwg_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int UOP_W = 4,
    parameter int CNT_W = 8,
    localparam int BW   = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [UOP_W-1:0] in_uops,
    input  logic             rob_ok,
    input  logic             ren_ok,
    input  logic             sch_ok,
    input  logic             cycle_tick,
    output logic             fire,
    output logic [BW-1:0]    budget_left,
    output logic [UOP_W-1:0] carry_left,
    output logic [1:0]       gate_state,
    output logic [CNT_W-1:0] stall_rob,
    output logic [CNT_W-1:0] stall_ren,
    output logic [CNT_W-1:0] stall_sch
);

    logic [NUM_CAUSES-1:0]       hit;
    logic [NUM_CAUSES*CNT_W-1:0] counts;
    gate_state_e                 st;

    dwg_admit #(.WIDTH(WIDTH), .UOP_W(UOP_W), .BW(BW)) u_admit (
        .in_valid  (in_valid),
        .in_uops   (in_uops),
        .rob_ok    (rob_ok),
        .ren_ok    (ren_ok),
        .sch_ok    (sch_ok),
        .budget    (budget_left),
        .fire      (fire),
        .stall_hit (hit)
    );

    dwg_budget #(.WIDTH(WIDTH), .UOP_W(UOP_W), .BW(BW)) u_budget (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .uops     (in_uops),
        .tick     (cycle_tick),
        .budget_o (budget_left),
        .carry_o  (carry_left),
        .state_o  (st)
    );

    dwg_stall_ctr #(.CNT_W(CNT_W), .N(NUM_CAUSES)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .count (counts)
    );

    assign gate_state = st;
    assign stall_rob  = counts[C_ROB*CNT_W +: CNT_W];
    assign stall_ren  = counts[C_REN*CNT_W +: CNT_W];
    assign stall_sch  = counts[C_SCH*CNT_W +: CNT_W];

endmodule

// File: rtl/dwg_gate_chk.sv
module dwg_gate_chk #(
    parameter int WIDTH = 4,
    parameter int UOP_W = 4,
    parameter int CNT_W = 8,
    parameter int BW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [UOP_W-1:0] in_uops,
    input logic             rob_ok,
    input logic             ren_ok,
    input logic             sch_ok,
    input logic             cycle_tick,
    input logic             fire,
    input logic [BW-1:0]    budget_left,
    input logic [UOP_W-1:0] carry_left,
    input logic [1:0]       gate_state,
    input logic [CNT_W-1:0] stall_rob,
    input logic [CNT_W-1:0] stall_ren,
    input logic [CNT_W-1:0] stall_sch
);

    p_fire_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> in_valid);

    p_fire_needs_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (rob_ok && ren_ok && sch_ok));

    p_budget_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        budget_left <= BW'(WIDTH));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cycle_tick && !fire) |=> ($stable(budget_left) && $stable(carry_left)));

    p_one_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones({stall_rob != $past(stall_rob),
                              stall_ren != $past(stall_ren),
                              stall_sch != $past(stall_sch)}) <= 1));

    p_no_fire_drained_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (budget_left == '0) |-> !fire);

    p_no_stall_drained_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (budget_left == '0) |=> ($stable(stall_rob) && $stable(stall_ren) && $stable(stall_sch)));

    p_sat_rob_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&stall_rob) |=> (&stall_rob));

    p_sat_sch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&stall_sch) |=> (&stall_sch));

    p_state_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gate_state == ((budget_left == BW'(WIDTH)) ? 2'd0 :
                       (budget_left == '0)         ? 2'd2 : 2'd1));

endmodule

bind dispatch_width_gate dwg_gate_chk #(
    .WIDTH(WIDTH), .UOP_W(UOP_W), .CNT_W(CNT_W), .BW(BW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_uops     (in_uops),
    .rob_ok      (rob_ok),
    .ren_ok      (ren_ok),
    .sch_ok      (sch_ok),
    .cycle_tick  (cycle_tick),
    .fire        (fire),
    .budget_left (budget_left),
    .carry_left  (carry_left),
    .gate_state  (gate_state),
    .stall_rob   (stall_rob),
    .stall_ren   (stall_ren),
    .stall_sch   (stall_sch)
);

// File: tb/dispatch_width_gate_tb_top.sv
module dispatch_width_gate_tb_top;

    localparam int W    = 3;
    localparam int UW   = 3;
    localparam int CW   = 3;
    localparam int BW   = $clog2(W + 1);
    localparam int SMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [UW-1:0] in_uops = '0;
    logic          rob_ok = 1'b1, ren_ok = 1'b1, sch_ok = 1'b1;
    logic          cycle_tick = 1'b0;
    logic          fire;
    logic [BW-1:0] budget_left;
    logic [UW-1:0] carry_left;
    logic [1:0]    gate_state;
    logic [CW-1:0] stall_rob, stall_ren, stall_sch;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int mb, mc, crob, cren, csch;

    always #5 clk = ~clk;

    dispatch_width_gate #(.WIDTH(W), .UOP_W(UW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
        .rob_ok(rob_ok), .ren_ok(ren_ok), .sch_ok(sch_ok),
        .cycle_tick(cycle_tick), .fire(fire), .budget_left(budget_left),
        .carry_left(carry_left), .gate_state(gate_state),
        .stall_rob(stall_rob), .stall_ren(stall_ren), .stall_sch(stall_sch)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_state(input int b);
        return (b == W) ? 0 : ((b == 0) ? 2 : 1);
    endfunction

    // one offered instruction; ok bit0 reorder buffer, bit1 rename, bit2 scheduler
    task automatic step(input int v, input int u, input int ok, input int tk);
        int cand, efire;
        @(negedge clk);
        in_valid   = v[0];
        in_uops    = UW'(u);
        rob_ok     = ok[0];
        ren_ok     = ok[1];
        sch_ok     = ok[2];
        cycle_tick = tk[0];
        #1;
        cand  = (v != 0 && mb != 0 && (u <= mb || mb == W)) ? 1 : 0;
        efire = (cand != 0 && ok == 7) ? 1 : 0;
        if (mb == 0) chk("R8 fire low at zero budget", int'(fire), 0);
        else if (ok == 7) chk("R2 fit rule fire", int'(fire), efire);
        else chk("R3 resource gating fire", int'(fire), efire);
        if (cand != 0 && ok != 7) begin
            if (ok[0] == 0)      crob = (crob < SMAX) ? crob + 1 : crob;
            else if (ok[1] == 0) cren = (cren < SMAX) ? cren + 1 : cren;
            else                 csch = (csch < SMAX) ? csch + 1 : csch;
        end
        if (efire != 0) begin
            if (u > mb) begin mc = mc + u - mb; mb = 0; end
            else mb = mb - u;
        end
        if (tk != 0) begin
            if (mc >= W) begin mb = 0; mc = mc - W; end
            else begin mb = W - mc; mc = 0; end
        end
        @(posedge clk);
        #1;
        if (tk != 0) begin
            chk("R5 boundary budget", int'(budget_left), mb);
            chk("R5 boundary carry", int'(carry_left), mc);
        end else if (efire != 0) begin
            chk("R4 spend budget", int'(budget_left), mb);
            chk("R4 spend carry", int'(carry_left), mc);
        end else begin
            chk("R6 hold budget", int'(budget_left), mb);
            chk("R6 hold carry", int'(carry_left), mc);
        end
        chk("R7 stall_rob", int'(stall_rob), crob);
        chk("R7 stall_ren", int'(stall_ren), cren);
        chk("R9 stall_sch saturating", int'(stall_sch), csch);
        chk("R10 gate_state", int'(gate_state), exp_state(mb));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        mb = W; mc = 0; crob = 0; cren = 0; csch = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset budget", int'(budget_left), W);
        chk("R1 reset carry", int'(carry_left), 0);
        chk("R1 reset state", int'(gate_state), 0);
        chk("R1 reset counters", int'(stall_rob) + int'(stall_ren) + int'(stall_sch), 0);

        // directed: oversized instruction spanning later cycles
        step(1, 7, 7, 0);   // R4: budget 0, carry 4
        step(1, 1, 0, 0);   // R8: drained, no stall
        step(0, 0, 7, 1);   // R5: budget 0, carry 1
        step(0, 0, 7, 1);   // R5: budget 2, carry 0
        step(1, 3, 6, 0);   // R2: does not fit, no stall
        step(1, 2, 5, 0);   // R7: rename stall
        step(1, 2, 7, 0);   // R4: exact spend to 0
        step(0, 0, 7, 1);   // R5: refill
        step(1, 0, 7, 0);   // R2: zero micro-ops admitted at full budget

        // near-exhaustive sweep
        for (int rep = 0; rep < 2; rep++)
            for (int tk = 0; tk < 2; tk++)
                for (int ok = 0; ok < 8; ok++)
                    for (int u = 0; u < 8; u++)
                        for (int v = 0; v < 2; v++)
                            step(v, (u + rep * 3) % 8, ok, (tk + u + rep) % 2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule